// File: doc/BRIEF.md
# Page Translation Buffer with Hardware Table Walk

This block turns 48-bit virtual addresses into 44-bit physical addresses for 4 KB pages. It keeps a small fully associative set of recent translations. When a request's page number is not held, it reads the matching word from a flat page table in memory, stores the translation and runs the lookup again. A page marked non-resident in the table produces a fault response in place of an address.

The block also keeps the use and modify status of each page. Any access marks the page as referenced, and a write marks it dirty. A status bit that changes is written both to the buffer and to the page-table word before the response goes out. The requester handles one translation at a time through a valid/ready request channel and a valid/ready response channel. The table is read and written through a single-outstanding word port. A flush input clears every held translation when the block is idle.

Top module: `walk_tlb`

## Requirements
- R1: A translated response carries `rsp_paddr = {ppn, vaddr[11:0]}`: the low 12 bits pass through unchanged and the upper 32 bits are the page's physical page number.
- R2: A table word is read at address `pt_base + vpn*8`, where vpn is `vaddr[47:12]`. Its layout is: bit 0 present, bit 1 referenced, bit 2 dirty, bits 63:32 physical page number, all other bits zero.
- R3: On a miss the block makes exactly one table read, installs the entry and responds with its translation. A later request to the same page makes no table read.
- R4: If the fetched word has bit 0 clear, the response has `rsp_fault=1` and `rsp_paddr=0`. Nothing is installed, so a repeated request reads the table again.
- R5: Any access whose stored referenced bit is clear produces one table write of the updated word at the same address before the response.
- R6: A write access sets the dirty bit. The written-back word then has bits 2:0 = 3'b111.
- R7: When the referenced bit, and the dirty bit for a write, are already set, no table write occurs.
- R8: When all entries are valid, a refill replaces the least recently used entry. A hit counts as a use.
- R9: A `flush` pulse while idle invalidates every entry. A `flush` raised while a request is in flight has no effect.
- R10: `req_ready` is low from the cycle after a request is accepted until its response is taken. A response is held with stable `rsp_paddr` and `rsp_fault` while `rsp_ready` is low, and it never appears in the cycle right after acceptance.
- R11: `mem_valid`, `mem_write` and `mem_addr` stay stable until `mem_ready`. No response is valid while a memory transaction is pending.
- R12: After reset `req_ready=1`, `rsp_valid=0` and `mem_valid=0`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| flush | input | 1 | Invalidate all entries (honoured only when idle) |
| pt_base | input | 44 | Physical byte address of the page table |
| req_valid | input | 1 | Translation request valid |
| req_ready | output | 1 | Block can accept a request |
| req_vaddr | input | 48 | Virtual address to translate |
| req_write | input | 1 | 1 for a store access, 0 for a load |
| rsp_valid | output | 1 | Response valid |
| rsp_ready | input | 1 | Requester takes the response |
| rsp_paddr | output | 44 | Physical address (zero on fault) |
| rsp_fault | output | 1 | Page not resident |
| mem_valid | output | 1 | Memory transaction request |
| mem_ready | input | 1 | Memory accepts the transaction |
| mem_write | output | 1 | 1 write, 0 read |
| mem_addr | output | 44 | Table word address |
| mem_wdata | output | 64 | Updated table word |
| mem_rvalid | input | 1 | Read data strobe |
| mem_rdata | input | 64 | Read table word |

## Verification
Corrupted entry state shows up at the response port on the next request to that page: a stale or wrong page number appears in `rsp_paddr` within two cycles of acceptance. A lost valid bit shows up as an extra table read on the memory port. Wrong recency ordering shows up only later, when a full buffer evicts an entry. A reload of a page that should have stayed resident then appears as an unexpected read one request after the eviction. Wrong status bits show up as a missing or extra table write, or a wrong low nibble in the written word, during the same transaction.

// File: rtl/walk_tlb_pkg.sv
package walk_tlb_pkg;
    localparam int VA_W     = 48;
    localparam int PA_W     = 44;
    localparam int OFS_W    = 12;
    localparam int VPN_W    = VA_W - OFS_W;
    localparam int PPN_W    = PA_W - OFS_W;
    localparam int PTE_W    = 64;
    localparam int PTE_LG   = 3;
    localparam int PRES_BIT = 0;
    localparam int REF_BIT  = 1;
    localparam int DIRT_BIT = 2;
    localparam int PPN_LSB  = PTE_W - PPN_W;

    typedef logic [VPN_W-1:0] vpn_t;
    typedef logic [PPN_W-1:0] ppn_t;

    typedef struct packed {
        logic valid;
        vpn_t vpn;
        ppn_t ppn;
        logic refd;
        logic dirty;
    } slot_t;

    typedef struct packed {
        logic present;
        ppn_t ppn;
        logic refd;
        logic dirty;
    } pte_t;

    typedef enum logic [2:0] {
        S_IDLE, S_LOOK, S_RDREQ, S_RDWAIT, S_WBREQ, S_RESP
    } walk_st_t;

    function automatic pte_t pte_unpack(input logic [PTE_W-1:0] w);
        pte_t p;
        p.present = w[PRES_BIT];
        p.refd    = w[REF_BIT];
        p.dirty   = w[DIRT_BIT];
        p.ppn     = w[PTE_W-1:PPN_LSB];
        return p;
    endfunction

    function automatic logic [PTE_W-1:0] pte_pack(input pte_t p);
        logic [PTE_W-1:0] w;
        w = '0;
        w[PRES_BIT] = p.present;
        w[REF_BIT]  = p.refd;
        w[DIRT_BIT] = p.dirty;
        w[PTE_W-1:PPN_LSB] = p.ppn;
        return w;
    endfunction

    function automatic logic [PA_W-1:0] pte_addr(input logic [PA_W-1:0] base, input vpn_t vpn);
        return base + PA_W'({vpn, {PTE_LG{1'b0}}});
    endfunction
endpackage

// File: rtl/walk_tlb_store.sv
module walk_tlb_store
    import walk_tlb_pkg::*;
#(
    parameter int DEPTH = 16,
    localparam int IDX_W = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clr,
    input  vpn_t             look_vpn,
    input  logic             inst_en,
    input  logic [IDX_W-1:0] inst_idx,
    input  ppn_t             inst_ppn,
    input  logic             inst_ref,
    input  logic             inst_dirty,
    input  logic             upd_en,
    input  logic [IDX_W-1:0] upd_idx,
    input  logic             upd_dirty,
    output logic             hit,
    output logic [IDX_W-1:0] hit_idx,
    output ppn_t             hit_ppn,
    output logic             hit_ref,
    output logic             hit_dirty,
    output logic [DEPTH-1:0] valid_vec
);
    slot_t            slots [DEPTH];
    logic [DEPTH-1:0] match;

    for (genvar g = 0; g < DEPTH; g++) begin : g_cmp
        assign match[g]     = slots[g].valid && (slots[g].vpn == look_vpn);
        assign valid_vec[g] = slots[g].valid;
    end

    always_comb begin
        hit     = 1'b0;
        hit_idx = '0;
        for (int i = 0; i < DEPTH; i++) begin
            if (match[i] && !hit) begin
                hit     = 1'b1;
                hit_idx = IDX_W'(i);
            end
        end
    end

    assign hit_ppn   = slots[hit_idx].ppn;
    assign hit_ref   = slots[hit_idx].refd;
    assign hit_dirty = slots[hit_idx].dirty;

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            for (int i = 0; i < DEPTH; i++) begin
                slots[i] <= '0;
            end
        end else if (inst_en) begin
            slots[inst_idx] <= '{valid: 1'b1, vpn: look_vpn, ppn: inst_ppn,
                                 refd: inst_ref, dirty: inst_dirty};
        end else if (upd_en) begin
            slots[upd_idx].refd  <= 1'b1;
            slots[upd_idx].dirty <= slots[upd_idx].dirty | upd_dirty;
        end
    end
endmodule

// File: rtl/walk_tlb_lru.sv
module walk_tlb_lru #(
    parameter int DEPTH = 16,
    localparam int IDX_W = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             touch_en,
    input  logic [IDX_W-1:0] touch_idx,
    input  logic [DEPTH-1:0] valid_vec,
    output logic [IDX_W-1:0] victim_idx
);
    logic [IDX_W-1:0] age [DEPTH];
    logic             found;

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) begin
                age[i] <= IDX_W'(i);
            end
        end else if (touch_en) begin
            for (int i = 0; i < DEPTH; i++) begin
                if (IDX_W'(i) == touch_idx) begin
                    age[i] <= '0;
                end else if (age[i] < age[touch_idx]) begin
                    age[i] <= age[i] + 1'b1;
                end
            end
        end
    end

    // Free slot first, otherwise the oldest one.
    always_comb begin
        found      = 1'b0;
        victim_idx = '0;
        for (int i = 0; i < DEPTH; i++) begin
            if (!valid_vec[i] && !found) begin
                found      = 1'b1;
                victim_idx = IDX_W'(i);
            end
        end
        if (!found) begin
            for (int i = 0; i < DEPTH; i++) begin
                if (age[i] == IDX_W'(DEPTH - 1)) begin
                    victim_idx = IDX_W'(i);
                end
            end
        end
    end
endmodule

// File: rtl/walk_tlb_ctrl.sv
module walk_tlb_ctrl
    import walk_tlb_pkg::*;
#(
    parameter int IDX_W = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             flush,
    input  logic [PA_W-1:0]  pt_base,
    input  logic             req_valid,
    output logic             req_ready,
    input  logic [VA_W-1:0]  req_vaddr,
    input  logic             req_write,
    output logic             rsp_valid,
    input  logic             rsp_ready,
    output logic [PA_W-1:0]  rsp_paddr,
    output logic             rsp_fault,
    output logic             mem_valid,
    input  logic             mem_ready,
    output logic             mem_write,
    output logic [PA_W-1:0]  mem_addr,
    output logic [PTE_W-1:0] mem_wdata,
    input  logic             mem_rvalid,
    input  logic [PTE_W-1:0] mem_rdata,
    output vpn_t             look_vpn,
    input  logic             hit,
    input  logic [IDX_W-1:0] hit_idx,
    input  ppn_t             hit_ppn,
    input  logic             hit_ref,
    input  logic             hit_dirty,
    input  logic [IDX_W-1:0] victim_idx,
    output logic             clr,
    output logic             inst_en,
    output logic [IDX_W-1:0] inst_idx,
    output ppn_t             inst_ppn,
    output logic             inst_ref,
    output logic             inst_dirty,
    output logic             upd_en,
    output logic [IDX_W-1:0] upd_idx,
    output logic             upd_dirty,
    output logic             touch_en,
    output logic [IDX_W-1:0] touch_idx
);
    walk_st_t          state;
    logic [VA_W-1:0]   vaddr_q;
    logic              wr_q;
    logic [PA_W-1:0]   paddr_q;
    logic              fault_q;
    logic [PTE_W-1:0]  wb_q;
    pte_t              fetched;
    pte_t              new_pte;
    logic              need_wb;

    assign look_vpn  = vaddr_q[VA_W-1:OFS_W];
    assign fetched   = pte_unpack(mem_rdata);

    assign req_ready = (state == S_IDLE) && !flush;
    assign clr       = (state == S_IDLE) && flush;
    assign rsp_valid = (state == S_RESP);
    assign rsp_paddr = paddr_q;
    assign rsp_fault = fault_q;

    assign mem_valid = (state == S_RDREQ) || (state == S_WBREQ);
    assign mem_write = (state == S_WBREQ);
    assign mem_addr  = pte_addr(pt_base, look_vpn);
    assign mem_wdata = wb_q;

    // Status bits after this access; write back only when one changes.
    always_comb begin
        new_pte.present = 1'b1;
        new_pte.ppn     = hit_ppn;
        new_pte.refd    = 1'b1;
        new_pte.dirty   = hit_dirty | wr_q;
        need_wb         = !hit_ref || (wr_q && !hit_dirty);
    end

    assign upd_en     = (state == S_LOOK) && hit;
    assign upd_idx    = hit_idx;
    assign upd_dirty  = wr_q;
    assign touch_en   = upd_en;
    assign touch_idx  = hit_idx;

    assign inst_en    = (state == S_RDWAIT) && mem_rvalid && fetched.present;
    assign inst_idx   = victim_idx;
    assign inst_ppn   = fetched.ppn;
    assign inst_ref   = fetched.refd;
    assign inst_dirty = fetched.dirty;

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= S_IDLE;
            vaddr_q <= '0;
            wr_q    <= 1'b0;
            paddr_q <= '0;
            fault_q <= 1'b0;
            wb_q    <= '0;
        end else begin
            case (state)
                S_IDLE: begin
                    if (req_valid && req_ready) begin
                        vaddr_q <= req_vaddr;
                        wr_q    <= req_write;
                        state   <= S_LOOK;
                    end
                end
                S_LOOK: begin
                    if (hit) begin
                        paddr_q <= {hit_ppn, vaddr_q[OFS_W-1:0]};
                        fault_q <= 1'b0;
                        wb_q    <= pte_pack(new_pte);
                        state   <= need_wb ? S_WBREQ : S_RESP;
                    end else begin
                        state <= S_RDREQ;
                    end
                end
                S_RDREQ: begin
                    if (mem_ready) state <= S_RDWAIT;
                end
                S_RDWAIT: begin
                    if (mem_rvalid) begin
                        if (fetched.present) begin
                            state <= S_LOOK;
                        end else begin
                            fault_q <= 1'b1;
                            paddr_q <= '0;
                            state   <= S_RESP;
                        end
                    end
                end
                S_WBREQ: begin
                    if (mem_ready) state <= S_RESP;
                end
                S_RESP: begin
                    if (rsp_ready) state <= S_IDLE;
                end
                default: state <= S_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/walk_tlb.sv
module walk_tlb
    import walk_tlb_pkg::*;
#(
    parameter int DEPTH = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             flush,
    input  logic [PA_W-1:0]  pt_base,
    input  logic             req_valid,
    output logic             req_ready,
    input  logic [VA_W-1:0]  req_vaddr,
    input  logic             req_write,
    output logic             rsp_valid,
    input  logic             rsp_ready,
    output logic [PA_W-1:0]  rsp_paddr,
    output logic             rsp_fault,
    output logic             mem_valid,
    input  logic             mem_ready,
    output logic             mem_write,
    output logic [PA_W-1:0]  mem_addr,
    output logic [PTE_W-1:0] mem_wdata,
    input  logic             mem_rvalid,
    input  logic [PTE_W-1:0] mem_rdata
);
    localparam int IDX_W = $clog2(DEPTH);

    vpn_t             look_vpn;
    logic             hit;
    logic [IDX_W-1:0] hit_idx;
    ppn_t             hit_ppn;
    logic             hit_ref;
    logic             hit_dirty;
    logic [DEPTH-1:0] valid_vec;
    logic [IDX_W-1:0] victim_idx;
    logic             clr;
    logic             inst_en;
    logic [IDX_W-1:0] inst_idx;
    ppn_t             inst_ppn;
    logic             inst_ref;
    logic             inst_dirty;
    logic             upd_en;
    logic [IDX_W-1:0] upd_idx;
    logic             upd_dirty;
    logic             touch_en;
    logic [IDX_W-1:0] touch_idx;

    walk_tlb_store #(.DEPTH(DEPTH)) u_store (
        .clk(clk), .rst(rst), .clr(clr), .look_vpn(look_vpn),
        .inst_en(inst_en), .inst_idx(inst_idx), .inst_ppn(inst_ppn),
        .inst_ref(inst_ref), .inst_dirty(inst_dirty),
        .upd_en(upd_en), .upd_idx(upd_idx), .upd_dirty(upd_dirty),
        .hit(hit), .hit_idx(hit_idx), .hit_ppn(hit_ppn),
        .hit_ref(hit_ref), .hit_dirty(hit_dirty), .valid_vec(valid_vec)
    );

    walk_tlb_lru #(.DEPTH(DEPTH)) u_lru (
        .clk(clk), .rst(rst), .touch_en(touch_en), .touch_idx(touch_idx),
        .valid_vec(valid_vec), .victim_idx(victim_idx)
    );

    walk_tlb_ctrl #(.IDX_W(IDX_W)) u_ctrl (
        .clk(clk), .rst(rst), .flush(flush), .pt_base(pt_base),
        .req_valid(req_valid), .req_ready(req_ready), .req_vaddr(req_vaddr),
        .req_write(req_write), .rsp_valid(rsp_valid), .rsp_ready(rsp_ready),
        .rsp_paddr(rsp_paddr), .rsp_fault(rsp_fault),
        .mem_valid(mem_valid), .mem_ready(mem_ready), .mem_write(mem_write),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata),
        .look_vpn(look_vpn), .hit(hit), .hit_idx(hit_idx), .hit_ppn(hit_ppn),
        .hit_ref(hit_ref), .hit_dirty(hit_dirty), .victim_idx(victim_idx),
        .clr(clr), .inst_en(inst_en), .inst_idx(inst_idx), .inst_ppn(inst_ppn),
        .inst_ref(inst_ref), .inst_dirty(inst_dirty),
        .upd_en(upd_en), .upd_idx(upd_idx), .upd_dirty(upd_dirty),
        .touch_en(touch_en), .touch_idx(touch_idx)
    );
endmodule

// File: rtl/walk_tlb_chk.sv
module walk_tlb_chk
    import walk_tlb_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic [PA_W-1:0]  pt_base,
    input logic             req_valid,
    input logic             req_ready,
    input logic             rsp_valid,
    input logic             rsp_ready,
    input logic [PA_W-1:0]  rsp_paddr,
    input logic             rsp_fault,
    input logic             mem_valid,
    input logic             mem_ready,
    input logic             mem_write,
    input logic [PA_W-1:0]  mem_addr
);
    assert_rsp_hold_R10: assert property (@(posedge clk) disable iff (rst)
        rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_paddr) && $stable(rsp_fault));

    assert_busy_R10: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |-> !req_ready);

    assert_no_early_rsp_R10: assert property (@(posedge clk) disable iff (rst)
        req_valid && req_ready |=> !rsp_valid);

    assert_mem_hold_R11: assert property (@(posedge clk) disable iff (rst)
        mem_valid && !mem_ready |=> mem_valid && $stable(mem_addr) && $stable(mem_write));

    assert_mem_before_rsp_R11: assert property (@(posedge clk) disable iff (rst)
        mem_valid |-> !rsp_valid);

    assert_word_stride_R2: assert property (@(posedge clk) disable iff (rst)
        mem_valid |-> ((mem_addr - pt_base) & PA_W'(7)) == '0);

    assert_fault_zero_R4: assert property (@(posedge clk) disable iff (rst)
        rsp_valid && rsp_fault |-> rsp_paddr == '0);
endmodule

bind walk_tlb walk_tlb_chk u_chk (
    .clk(clk), .rst(rst), .pt_base(pt_base),
    .req_valid(req_valid), .req_ready(req_ready),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready),
    .rsp_paddr(rsp_paddr), .rsp_fault(rsp_fault),
    .mem_valid(mem_valid), .mem_ready(mem_ready),
    .mem_write(mem_write), .mem_addr(mem_addr)
);

// File: tb/tb_walk_tlb.sv
`timescale 1ns/1ps
module tb_walk_tlb;
    localparam logic [43:0] BASE = 44'h0000_8000_000;

    typedef struct packed {
        logic [35:0] vpn;
        logic [11:0] off;
        logic        wr;
        logic        flt;
        logic [31:0] ppn;
        logic [3:0]  nrd;
        logic [3:0]  nwr;
    } vec_t;

    localparam int NV = 9;
    localparam vec_t VECS [NV] = '{
        vec_t'({36'd2, 12'h123, 1'b0, 1'b0, 32'h106, 4'd1, 4'd1}), // R3 R5 miss, ref newly set
        vec_t'({36'd2, 12'hFFF, 1'b0, 1'b0, 32'h106, 4'd0, 4'd0}), // R7 hit, nothing new
        vec_t'({36'd2, 12'h000, 1'b1, 1'b0, 32'h106, 4'd0, 4'd1}), // R6 dirty newly set
        vec_t'({36'd2, 12'h456, 1'b1, 1'b0, 32'h106, 4'd0, 4'd0}), // R7
        vec_t'({36'd5, 12'h010, 1'b0, 1'b1, 32'h000, 4'd1, 4'd0}), // R4 fault
        vec_t'({36'd5, 12'h010, 1'b1, 1'b1, 32'h000, 4'd1, 4'd0}), // R4 not installed
        vec_t'({36'd7, 12'hABC, 1'b1, 1'b0, 32'h115, 4'd1, 4'd1}), // R6 miss + write
        vec_t'({36'd7, 12'h001, 1'b0, 1'b0, 32'h115, 4'd0, 4'd0}), // R3 hit
        vec_t'({36'd9, 12'h777, 1'b0, 1'b0, 32'h11B, 4'd1, 4'd0})  // R7 ref preset
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        flush = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [47:0] req_vaddr = '0;
    logic        req_write = 1'b0;
    logic        rsp_valid;
    logic        rsp_ready = 1'b1;
    logic [43:0] rsp_paddr;
    logic        rsp_fault;
    logic        mem_valid;
    logic        mem_ready = 1'b0;
    logic        mem_write;
    logic [43:0] mem_addr;
    logic [63:0] mem_wdata;
    logic        mem_rvalid = 1'b0;
    logic [63:0] mem_rdata = '0;

    logic [63:0] pt [64];
    int          rd_cnt = 0;
    int          wr_cnt = 0;
    logic [43:0] last_rd_addr = '0;
    int          checks = 0;
    int          errors = 0;

    always #10 clk = ~clk;

    walk_tlb dut (
        .clk(clk), .rst(rst), .flush(flush), .pt_base(BASE),
        .req_valid(req_valid), .req_ready(req_ready), .req_vaddr(req_vaddr),
        .req_write(req_write), .rsp_valid(rsp_valid), .rsp_ready(rsp_ready),
        .rsp_paddr(rsp_paddr), .rsp_fault(rsp_fault),
        .mem_valid(mem_valid), .mem_ready(mem_ready), .mem_write(mem_write),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata)
    );

    // Page-table memory: ready every other cycle, read data one cycle later.
    always @(posedge clk) begin
        mem_rvalid <= 1'b0;
        mem_ready  <= ~mem_ready;
        if (!rst && mem_valid && mem_ready) begin
            if (mem_write) begin
                pt[6'((mem_addr - BASE) >> 3)] <= mem_wdata;
                wr_cnt <= wr_cnt + 1;
            end else begin
                mem_rdata    <= pt[6'((mem_addr - BASE) >> 3)];
                mem_rvalid   <= 1'b1;
                last_rd_addr <= mem_addr;
                rd_cnt       <= rd_cnt + 1;
            end
        end
    end

    function automatic logic [31:0] ppn_of(input int v);
        return 32'h100 + 32'(v * 3);
    endfunction

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    task automatic xlate(input logic [35:0] vpn, input logic [11:0] off, input logic wr,
                         input bit mid_flush, input int hold,
                         output logic flt, output logic [43:0] pa,
                         output int nrd, output int nwr);
        int r0, w0;
        @(negedge clk);
        r0 = rd_cnt; w0 = wr_cnt;
        req_vaddr = {vpn, off};
        req_write = wr;
        req_valid = 1'b1;
        if (hold > 0) rsp_ready = 1'b0;
        @(negedge clk);
        req_valid = 1'b0;
        if (mid_flush) begin
            flush = 1'b1;
            @(negedge clk);
            flush = 1'b0;
        end
        while (!rsp_valid) @(negedge clk);
        flt = rsp_fault;
        pa  = rsp_paddr;
        nrd = rd_cnt - r0;
        nwr = wr_cnt - w0;
        for (int k = 0; k < hold; k++) begin
            @(negedge clk);
            chk("R10 response held", {62'd0, rsp_valid, req_ready}, 64'd2);
            chk("R10 paddr stable", 64'(rsp_paddr), 64'(pa));
        end
        rsp_ready = 1'b1;
    endtask

    task automatic pulse_flush();
        @(negedge clk);
        flush = 1'b1;
        @(negedge clk);
        flush = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        logic        flt;
        logic [43:0] pa;
        int          nrd, nwr;
        for (int v = 0; v < 64; v++) begin
            pt[v] = {ppn_of(v), 29'd0, (v == 9) ? 2'b01 : 2'b00,
                     (v == 5 || v == 33) ? 1'b0 : 1'b1};
        end
        repeat (3) @(negedge clk);
        chk("R12 reset outputs", {61'd0, req_ready, rsp_valid, mem_valid}, 64'b100);
        rst = 1'b0;
        @(negedge clk);
        chk("R12 idle after reset", {61'd0, req_ready, rsp_valid, mem_valid}, 64'b100);

        for (int i = 0; i < NV; i++) begin
            xlate(VECS[i].vpn, VECS[i].off, VECS[i].wr, 1'b0, 0, flt, pa, nrd, nwr);
            chk("R4 fault flag", 64'(flt), 64'(VECS[i].flt));
            if (VECS[i].flt) chk("R4 zero paddr", 64'(pa), 64'd0);
            else chk("R1 paddr", 64'(pa), 64'({VECS[i].ppn, VECS[i].off}));
            chk("R3 table reads", 64'(nrd), 64'(VECS[i].nrd));
            chk("R5/R6/R7 table writes", 64'(nwr), 64'(VECS[i].nwr));
            if (nrd > 0) chk("R2 read address", 64'(last_rd_addr), 64'(BASE + 44'(VECS[i].vpn * 8)));
        end
        chk("R6 word of page 2", pt[2], {32'h106, 29'd0, 3'b111});
        chk("R6 word of page 7", pt[7], {32'h115, 29'd0, 3'b111});
        chk("R7 word of page 9 untouched", pt[9], {32'h11B, 29'd0, 3'b011});

        // R10: response held while the requester stalls
        xlate(36'd2, 12'h0AA, 1'b0, 1'b0, 3, flt, pa, nrd, nwr);
        chk("R10 held paddr", 64'(pa), 64'({32'h106, 12'h0AA}));

        // R9: flush in flight is ignored; page 7 stays held
        xlate(36'd7, 12'h002, 1'b0, 1'b1, 0, flt, pa, nrd, nwr);
        xlate(36'd7, 12'h003, 1'b0, 1'b0, 0, flt, pa, nrd, nwr);
        chk("R9 busy flush ignored", 64'(nrd), 64'd0);
        pulse_flush();
        xlate(36'd7, 12'h004, 1'b0, 1'b0, 0, flt, pa, nrd, nwr);
        chk("R9 idle flush clears", 64'(nrd), 64'd1);
        chk("R9 paddr after refill", 64'(pa), 64'({32'h115, 12'h004}));

        // R8: fill all 16 slots, reuse the oldest, then force an eviction
        pulse_flush();
        for (int v = 10; v < 26; v++) begin
            xlate(36'(v), 12'h000, 1'b0, 1'b0, 0, flt, pa, nrd, nwr);
        end
        xlate(36'd10, 12'h000, 1'b0, 1'b0, 0, flt, pa, nrd, nwr);
        chk("R8 fill hit", 64'(nrd), 64'd0);
        xlate(36'd26, 12'h000, 1'b0, 1'b0, 0, flt, pa, nrd, nwr);
        chk("R8 new page read", 64'(nrd), 64'd1);
        xlate(36'd10, 12'h000, 1'b0, 1'b0, 0, flt, pa, nrd, nwr);
        chk("R8 recently used kept", 64'(nrd), 64'd0);
        xlate(36'd11, 12'h5A5, 1'b0, 1'b0, 0, flt, pa, nrd, nwr);
        chk("R8 oldest evicted", 64'(nrd), 64'd1);
        chk("R1 paddr after reload", 64'(pa), 64'({ppn_of(11), 12'h5A5}));

        finish_run();
    end
endmodule